// File: doc/BRIEF.md
# Bridge I/O Window Forwarding Decoder

This block makes the forward-or-ignore decision that a PCI-to-PCI bridge applies to host I/O cycles. It keeps a bridge-style command register and the I/O base and limit registers, which are programmed and read back through a small indexed configuration port. From the upper nibbles of the base and limit bytes, plus optional upper-16 extension registers, it builds a window with 4 KB granularity. The window start has its low 12 bits cleared and the window end has its low 12 bits set.

Each cycle that the I/O address strobe is high, the block answers one clock later with a single-cycle forward pulse or a single-cycle ignore pulse. Nothing is forwarded while the I/O space enable is clear, or while the window is inverted (start above end). The reset state is such an inverted window, so an unprogrammed bridge claims nothing.

Top module: `io_window_decoder`

## Requirements
- R1: After reset the command register reads 0x0000, the base byte (index 1) reads 0xF1 and the limit byte (index 2) reads 0x01, and no address is forwarded.
- R2: With the I/O enable set, the upper nibble of the base byte is window-start bits 15:12 with bits 11:0 zero, and the upper nibble of the limit byte is window-end bits 15:12 with bits 11:0 one. An address is forwarded only when start ≤ address ≤ end. For example, base 0x80 and limit 0x80 forward 0x8000, 0x8390 and 0x8FFF, and ignore 0x7FFF and 0x9000.
- R3: The low nibble of the base and limit bytes is a read-only capability code: 0x1 when 32-bit addressing is built in (the default), 0x0 otherwise. Writes do not change it.
- R4: Command bit 0 is the I/O space enable. While it is clear, every strobed address is ignored.
- R5: A window whose full start lies above its full end is closed, and forwards nothing.
- R6: In 32-bit mode, index 3 (base upper 16) and index 4 (limit upper 16) supply address bits 31:16 of the window start and end. While both are zero, no address at or above 0x10000 is forwarded.
- R7: A configuration write takes effect on the clock edge of its strobe. A decision strobed in that same cycle still uses the old values, and the next cycle uses the new values.
- R8: For every cycle with the address strobe high, exactly one of the forward or ignore outputs pulses in the following cycle. Neither output is high in any other cycle.
- R9: All 16 command bits read back as written. Indices 5 to 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Register index: 0 command, 1 base byte, 2 limit byte, 3 base upper, 4 limit upper |
| cfg_wdata | input | 16 | Write data (the byte registers use bits 7:0) |
| cfg_rdata | output | 16 | Read data for cfg_idx, from the registered state |
| io_stb | input | 1 | Single-cycle I/O address strobe |
| io_addr | input | 32 | I/O address qualified by io_stb |
| io_fwd | output | 1 | Pulse one cycle after the strobe: forward the cycle |
| io_ign | output | 1 | Pulse one cycle after the strobe: ignore the cycle |

## Verification
The assertions check the following on every cycle: the one-answer-per-strobe timing, that a clear enable or a closed window never forwards, that every forward lies inside the window held at strobe time, that addresses above the upper limit are refused, and that a command write shows up one edge later. Some behaviour only the bench scenarios can show, because no single cycle reveals it. This covers the read-only capability nibble, the exact inclusive edges 0x8000 and 0x8FFF against 0x7FFF and 0x9000, the reset contents, and the old-value decision made in the cycle of a write. A behavioural reference model predicts both decision outputs on every clock.

// File: rtl/io_win_pkg.sv
// io_win_pkg: shared constants and the register index map for the bridge
// I/O window decoder. Assumes a 3-bit register index and a 16-bit config bus.
package io_win_pkg;

    localparam int CFG_IW    = 3;
    localparam int CFG_DW    = 16;
    localparam int GRAN_BITS = 12;   // 4 KB window granularity

    typedef enum logic [CFG_IW-1:0] {
        IDX_CMD      = 3'd0,
        IDX_BASE     = 3'd1,
        IDX_LIMIT    = 3'd2,
        IDX_BASE_UP  = 3'd3,
        IDX_LIMIT_UP = 3'd4
    } cfg_idx_e;

    // Reset nibbles form an inverted window (0xF000 > 0x0FFF).
    localparam logic [3:0] RST_BASE_NIB  = 4'hF;
    localparam logic [3:0] RST_LIMIT_NIB = 4'h0;

endpackage

// File: rtl/io_win_regs.sv
// io_win_regs: configuration register file for the I/O window.
// Holds the command word, the upper nibbles of the base and limit bytes and,
// when IO32 is set, the upper-16 extension registers. The low nibble of the
// byte registers is a constant capability code. Writes land on the strobe
// edge. Reads are combinational from the registers.
// Assumes UP_W <= 16 (the upper registers fit on the config data bus).
module io_win_regs
    import io_win_pkg::*;
#(
    parameter bit IO32   = 1'b1,
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_IW-1:0]   cfg_idx,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    output logic [CFG_DW-1:0]   cfg_rdata,
    output logic [CFG_DW-1:0]   cmd_q,
    output logic [3:0]          base_nib_q,
    output logic [3:0]          limit_nib_q,
    output logic [ADDR_W-17:0]  base_up_q,
    output logic [ADDR_W-17:0]  limit_up_q
);

    localparam int         UP_W    = ADDR_W - 16;
    localparam logic [3:0] CAP_NIB = IO32 ? 4'h1 : 4'h0;

    logic wr_cmd, wr_base, wr_limit;

    // Decode the write strobe per register.
    always_comb begin
        wr_cmd   = cfg_wr && (cfg_idx == IDX_CMD);
        wr_base  = cfg_wr && (cfg_idx == IDX_BASE);
        wr_limit = cfg_wr && (cfg_idx == IDX_LIMIT);
    end

    // Command word and base/limit nibbles, reset to a disabled, closed window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            base_nib_q  <= RST_BASE_NIB;
            limit_nib_q <= RST_LIMIT_NIB;
        end else begin
            if (wr_cmd)   cmd_q       <= cfg_wdata;
            if (wr_base)  base_nib_q  <= cfg_wdata[7:4];
            if (wr_limit) limit_nib_q <= cfg_wdata[7:4];
        end
    end

    generate
        if (IO32) begin : g_up
            // Upper-16 extension registers, present only with 32-bit I/O.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_up_q  <= '0;
                    limit_up_q <= '0;
                end else begin
                    if (cfg_wr && cfg_idx == IDX_BASE_UP)  base_up_q  <= cfg_wdata[UP_W-1:0];
                    if (cfg_wr && cfg_idx == IDX_LIMIT_UP) limit_up_q <= cfg_wdata[UP_W-1:0];
                end
            end
        end else begin : g_no_up
            assign base_up_q  = '0;
            assign limit_up_q = '0;
        end
    endgenerate

    // Read mux; unmapped indices return zero.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_idx)
            IDX_CMD:      cfg_rdata = cmd_q;
            IDX_BASE:     cfg_rdata = {8'h00, base_nib_q, CAP_NIB};
            IDX_LIMIT:    cfg_rdata = {8'h00, limit_nib_q, CAP_NIB};
            IDX_BASE_UP:  cfg_rdata[UP_W-1:0] = base_up_q;
            IDX_LIMIT_UP: cfg_rdata[UP_W-1:0] = limit_up_q;
            default:      cfg_rdata = '0;
        endcase
    end

    // R7: a command write is visible on the following cycle.
    a_r7_cmd_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> (cmd_q == $past(cfg_wdata)));

endmodule

// File: rtl/io_win_bounds.sv
// io_win_bounds: rebuilds the full window start and end from the register
// fields and flags whether the window is open (start not above end).
// Purely combinational. Assumes ADDR_W = 16 + upper-field width.
module io_win_bounds
    import io_win_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [3:0]         base_nib,
    input  logic [3:0]         limit_nib,
    input  logic [ADDR_W-17:0] base_up,
    input  logic [ADDR_W-17:0] limit_up,
    output logic [ADDR_W-1:0]  win_lo,
    output logic [ADDR_W-1:0]  win_hi,
    output logic               win_open
);

    // Concatenate the fields; the granularity bits are zero at the start and one at the end.
    always_comb begin
        win_lo   = {base_up,  base_nib,  {GRAN_BITS{1'b0}}};
        win_hi   = {limit_up, limit_nib, {GRAN_BITS{1'b1}}};
        win_open = (win_lo <= win_hi);
    end

endmodule

// File: rtl/io_win_match.sv
// io_win_match: compares a strobed address against the window and registers
// a one-cycle forward or ignore pulse. It assumes io_stb lasts one cycle per
// address, and that the window inputs come from registered state.
module io_win_match #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_stb,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_en,
    input  logic              win_open,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    output logic              fwd_q,
    output logic              ign_q
);

    logic in_range, claim;

    // Inclusive range test gated by the enable and the open flag.
    always_comb begin
        in_range = (io_addr >= win_lo) && (io_addr <= win_hi);
        claim    = io_en && win_open && in_range;
    end

    // Register the decision as a pulse on exactly one output per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_q <= 1'b0;
            ign_q <= 1'b0;
        end else begin
            fwd_q <= io_stb && claim;
            ign_q <= io_stb && !claim;
        end
    end

    // R8: one answer per strobe, none otherwise.
    a_r8_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        io_stb |=> (fwd_q ^ ign_q));
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !io_stb |=> !(fwd_q || ign_q));
    // R4: disabled I/O space never forwards.
    a_r4_disabled_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (io_stb && !io_en) |=> !fwd_q);
    // R5: a closed window never forwards.
    a_r5_closed_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (io_stb && !win_open) |=> !fwd_q);
    // R2: every forward was inside the window at strobe time.
    a_r2_fwd_inside: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_q |-> ($past(io_addr) >= $past(win_lo) && $past(io_addr) <= $past(win_hi)));

endmodule

// File: rtl/io_window_decoder.sv
// io_window_decoder: top of the bridge I/O window forwarding decoder.
// It ties the register file, the bound builder and the matcher together.
// Decisions use the registered configuration only, so a write and a strobe
// in the same cycle see the old settings.
module io_window_decoder
    import io_win_pkg::*;
#(
    parameter bit IO32   = 1'b1,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_idx,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              io_stb,
    input  logic [31:0]       io_addr,
    output logic              io_fwd,
    output logic              io_ign
);

    localparam int UP_W = ADDR_W - 16;

    logic [CFG_DW-1:0] cmd_q;
    logic [3:0]        base_nib, limit_nib;
    logic [UP_W-1:0]   base_up, limit_up;
    logic [ADDR_W-1:0] win_lo, win_hi;
    logic              win_open;

    io_win_regs #(.IO32(IO32), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_idx     (cfg_idx),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .cmd_q       (cmd_q),
        .base_nib_q  (base_nib),
        .limit_nib_q (limit_nib),
        .base_up_q   (base_up),
        .limit_up_q  (limit_up)
    );

    io_win_bounds #(.ADDR_W(ADDR_W)) u_bounds (
        .base_nib  (base_nib),
        .limit_nib (limit_nib),
        .base_up   (base_up),
        .limit_up  (limit_up),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .win_open  (win_open)
    );

    io_win_match #(.ADDR_W(ADDR_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_stb   (io_stb),
        .io_addr  (io_addr),
        .io_en    (cmd_q[0]),
        .win_open (win_open),
        .win_lo   (win_lo),
        .win_hi   (win_hi),
        .fwd_q    (io_fwd),
        .ign_q    (io_ign)
    );

    // R6: addresses above the upper limit field are never forwarded.
    a_r6_above_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (io_stb && io_addr[ADDR_W-1:16] > limit_up) |=> !io_fwd);

endmodule

// File: tb/io_window_decoder_tb.sv
// io_window_decoder_tb: directed scenarios and a behavioural reference model
// that predicts io_fwd and io_ign on every clock.
module io_window_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        io_stb = 1'b0;
    logic [31:0] io_addr = '0;
    logic        io_fwd, io_ign;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state.
    longint m_cmd, m_bn, m_ln, m_bu, m_lu;
    bit exp_f = 1'b0, exp_i = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_window_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_stb(io_stb),
        .io_addr(io_addr), .io_fwd(io_fwd), .io_ign(io_ign)
    );

    function automatic bit model_hit(longint a);
        longint lo, hi;
        lo = m_bu * 65536 + m_bn * 4096;
        hi = m_lu * 65536 + m_ln * 4096 + 4095;
        return (m_cmd % 2 == 1) && (lo <= hi) && (a >= lo) && (a <= hi);
    endfunction

    // Model update: the decision uses the old state, then the write applies.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = 0; m_bn = 15; m_ln = 0; m_bu = 0; m_lu = 0;
            exp_f = 1'b0; exp_i = 1'b0;
        end else begin
            exp_f = io_stb && model_hit(longint'(io_addr));
            exp_i = io_stb && !exp_f;
            if (cfg_wr) begin
                case (cfg_idx)
                    3'd0: m_cmd = longint'(cfg_wdata);
                    3'd1: m_bn  = longint'(cfg_wdata[7:4]);
                    3'd2: m_ln  = longint'(cfg_wdata[7:4]);
                    3'd3: m_bu  = longint'(cfg_wdata);
                    3'd4: m_lu  = longint'(cfg_wdata);
                    default: ;
                endcase
            end
        end
    end

    // R8: every-clock comparison of both decision outputs against the model.
    always @(negedge clk) begin
        if (!done) begin
            n_run++;
            if (io_fwd !== exp_f || io_ign !== exp_i) begin
                n_fail++;
                $display("FAIL R8 model: fwd/ign=%0b%0b expected %0b%0b at %0t",
                         io_fwd, io_ign, exp_f, exp_i, $time);
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] i, output logic [15:0] d);
        @(negedge clk);
        cfg_idx = i;
        #1 d = cfg_rdata;
    endtask

    task automatic probe(input logic [31:0] a, input string tag, input bit fwd_exp);
        @(negedge clk);
        io_stb = 1'b1; io_addr = a;
        @(negedge clk);
        io_stb = 1'b0;
        #1;
        check(tag, {30'd0, io_fwd, io_ign}, {30'd0, fwd_exp, !fwd_exp});
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents and closed window.
        rd(3'd0, v); check("R1 cmd reset", {16'd0, v}, 32'h0000);
        rd(3'd1, v); check("R1 base reset", {16'd0, v}, 32'h00F1);
        rd(3'd2, v); check("R1 limit reset", {16'd0, v}, 32'h0001);
        probe(32'h0000_8000, "R1 no forward after reset", 1'b0);

        // R9: command read-back; R4: window set but enable clear.
        wr(3'd0, 16'h0404);
        rd(3'd0, v); check("R9 cmd readback", {16'd0, v}, 32'h0404);
        wr(3'd1, 16'h0080);
        wr(3'd2, 16'h0080);
        probe(32'h0000_8390, "R4 enable clear blocks", 1'b0);
        wr(3'd0, 16'h0405);
        rd(3'd0, v); check("R9 cmd readback enabled", {16'd0, v}, 32'h0405);

        // R2: window edges for base 0x80 / limit 0x80.
        probe(32'h0000_8390, "R2 0x8390 inside", 1'b1);
        probe(32'h0000_8000, "R2 start edge", 1'b1);
        probe(32'h0000_8FFF, "R2 end edge", 1'b1);
        probe(32'h0000_7FFF, "R2 below start", 1'b0);
        probe(32'h0000_9000, "R2 above end", 1'b0);

        // R3: capability nibble stays 1 on writes.
        wr(3'd1, 16'h0085);
        rd(3'd1, v); check("R3 base cap nibble", {16'd0, v}, 32'h0081);
        wr(3'd2, 16'h00FE);
        rd(3'd2, v); check("R3 limit cap nibble", {16'd0, v}, 32'h00F1);

        // R5: inverted window 0xF000..0x0FFF forwards nothing.
        wr(3'd1, 16'h00F0);
        wr(3'd2, 16'h0000);
        probe(32'h0000_F000, "R5 inverted at base", 1'b0);
        probe(32'h0000_0800, "R5 inverted low", 1'b0);

        // R6: upper-16 extension.
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h00F0);
        probe(32'h0000_F123, "R6 low window hit", 1'b1);
        probe(32'h0001_0100, "R6 above 64K with zero uppers", 1'b0);
        wr(3'd4, 16'h0001);
        probe(32'h0001_0100, "R6 limit upper extends", 1'b1);
        wr(3'd3, 16'h0002);
        probe(32'h0001_8000, "R6 R5 inverted by uppers", 1'b0);
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0000);

        // R7: a strobe in the write cycle uses the old enable.
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 3'd0; cfg_wdata = 16'h0000;
        io_stb = 1'b1; io_addr = 32'h0000_4000;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1 check("R7 old value in write cycle", {31'd0, io_fwd}, 32'd1);
        @(negedge clk);
        io_stb = 1'b0;
        #1 check("R7 new value next cycle", {31'd0, io_fwd}, 32'd0);

        // R9: unmapped index reads zero and a write changes nothing.
        wr(3'd5, 16'hBEEF);
        rd(3'd5, v); check("R9 unmapped reads zero", {16'd0, v}, 32'h0);
        rd(3'd0, v); check("R9 unmapped write no effect", {16'd0, v}, 32'h0);

        // R8: idle cycles produce no pulses.
        repeat (3) @(negedge clk);
        #1 check("R8 idle quiet", {30'd0, io_fwd, io_ign}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule